// File: doc/BRIEF.md
# Programmable Serial Baud Tick Generator

This block produces the timing enables for a serial transceiver. It takes one of four clock sources: the system clock itself, an enable from an external pre-divider, a reserved code, or an external serial clock pin. It divides the ticks of the chosen source by a 16-bit divisor, which gives the receiver sampling enable. That enable is divided again by 8 or by 16 to give the bit-rate enable. The bit rate is therefore the source rate divided by `8 * (2 - over) * divisor`. The highest rate is one bit every 8 system clocks, reached with the system clock as the source, a divisor of 1 and 8x oversampling.

Both outputs are pulses one system clock wide, not derived clocks. A divisor of 0 stops the sampling enable. A divisor of 1 forwards every source tick. Rising edges of the external pin are brought into the system clock domain before use. In synchronous operation with the external pin selected, each synchronized rising edge of that pin drives both outputs directly and the divider chain is bypassed.

Top module: `baud_gen`

## Requirements
- R1: While reset is low, `samp_en_o` and `baud_en_o` are 0. After release, both counters start from a cleared state.
- R2: With `src_sel_i` = 0 (every system clock is a tick) and a constant divisor N ≥ 2, `samp_en_o` pulses for one cycle every N cycles.
- R3: With a divisor of 1, every source tick produces a `samp_en_o` pulse. With `src_sel_i` = 0 this is a pulse every cycle, and with `src_sel_i` = 1 it is a pulse on every pre-divider enable.
- R4: With a divisor of 0 and no bypass, `samp_en_o` and `baud_en_o` stay at 0.
- R5: With `src_sel_i` = 1 the ticks are the cycles in which `prediv_en_i` is 1. Enables every M cycles with divisor N give a `samp_en_o` period of N·M cycles.
- R6: `src_sel_i` = 2 is reserved and supplies no ticks, so no pulses are produced unless bypass is active.
- R7: With `src_sel_i` = 3 and `sync_i` = 0, each rising edge of `ext_sck_i`, passed through a two-flop synchronizer, is one tick. A pin period of P cycles with divisor N gives a `samp_en_o` period of N·P cycles.
- R8: `baud_en_o` pulses only in a cycle in which `samp_en_o` also pulses. With `over_i` = 0 it marks every 16th sampling pulse, and with `over_i` = 1 every 8th.
- R9: With `sync_i` = 1 and `src_sel_i` = 3, `samp_en_o` and `baud_en_o` both pulse once per synchronized rising edge of `ext_sck_i`, whatever the divisor, including 0.
- R10: A change of the divisor or of `src_sel_i` reloads the divider at the next clock edge. With `src_sel_i` = 0 and a new divisor N, the first `samp_en_o` pulse appears N+1 cycles after the cycle in which the new value is applied.
- R11: A change of `over_i` clears the 8/16 counter. The sampling pulse in the cycle of the change does not count, and the first `baud_en_o` pulse after the change comes on the 8th or 16th following sampling pulse.
- R12: `sync_i` = 1 has no effect unless `src_sel_i` = 3, so normal division applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prediv_en_i | input | 1 | Tick enable from the external pre-divider (source 1) |
| ext_sck_i | input | 1 | External serial clock pin, asynchronous |
| src_sel_i | input | 2 | Source select: 0 system, 1 pre-divided, 2 reserved, 3 external pin |
| cd_i | input | CD_W (16) | Divisor: 0 stops, 1 passes ticks through |
| over_i | input | 1 | 0 selects 16x oversampling, 1 selects 8x |
| sync_i | input | 1 | Synchronous mode; with source 3 the divider chain is bypassed |
| samp_en_o | output | 1 | One-cycle sampling enable |
| baud_en_o | output | 1 | One-cycle bit-rate enable |

## Verification
The hardest cases to reach from the ports are the reload and restart points: the exact cycle of the first pulse after a divisor change, and the count that restarts when `over_i` flips while sampling pulses are already running. The stimulus applies each change on a falling edge while the block is running, then counts cycles or sampling pulses from that edge. This pins the latency to one exact value. The external-pin paths are driven by a background toggler with a known half period, and the pre-divided path by a background strobe generator. Random rounds mix source, divisor, strobe spacing and oversampling, and compare the measured spacing with the rate formula.

// File: rtl/bg_pkg.sv
package bg_pkg;
    // Source codes; the numeric values are the select field encoding.
    typedef enum logic [1:0] {
        SRC_SYS    = 2'd0,
        SRC_PREDIV = 2'd1,
        SRC_RSVD   = 2'd2,
        SRC_EXT    = 2'd3
    } bg_src_e;
endpackage

// File: rtl/bg_edge_sync.sv
// Synchronizes an asynchronous pin and flags its rising edges.
module bg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } es_state_t;

    es_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.last;
endmodule

// File: rtl/bg_divider.sv
// Divides source ticks by a programmable divisor; reloads on config change.
module bg_divider
    import bg_pkg::*;
#(
    parameter int CD_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic [CD_W-1:0] cd_i,
    input  bg_src_e         sel_i,
    output logic            samp_o
);
    localparam logic [CD_W-1:0] CD_ZERO = '0;
    localparam logic [CD_W-1:0] CD_ONE  = CD_W'(1);

    typedef struct packed {
        logic [CD_W-1:0] cnt;
        logic [CD_W-1:0] cd_seen;
        bg_src_e         sel_seen;
        logic            samp;
    } dv_state_t;

    dv_state_t st_d, st_q;
    logic      cfg_change;

    always_comb begin
        st_d          = st_q;
        st_d.samp     = 1'b0;
        st_d.cd_seen  = cd_i;
        st_d.sel_seen = sel_i;
        cfg_change    = (cd_i != st_q.cd_seen) || (sel_i != st_q.sel_seen);
        if (cfg_change) begin
            st_d.cnt = (cd_i == CD_ZERO) ? CD_ZERO : cd_i - CD_ONE;
        end else if (tick_i) begin
            if (cd_i == CD_ZERO) begin
                st_d.cnt = CD_ZERO;
            end else if (cd_i == CD_ONE) begin
                st_d.samp = 1'b1;
            end else if (st_q.cnt == CD_ZERO) begin
                st_d.cnt  = cd_i - CD_ONE;
                st_d.samp = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CD_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt      <= CD_ZERO;
            st_q.cd_seen  <= CD_ZERO;
            st_q.sel_seen <= SRC_SYS;
            st_q.samp     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_o = st_q.samp;
endmodule

// File: rtl/bg_oversamp.sv
// Counts sampling pulses and marks every FAST-th or SLOW-th one.
module bg_oversamp #(
    parameter int FAST = 8,
    parameter int SLOW = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic samp_i,
    input  logic over_i,
    output logic baud_o
);
    localparam int            OS_W      = $clog2(SLOW);
    localparam logic [OS_W-1:0] FAST_LAST = OS_W'(FAST - 1);
    localparam logic [OS_W-1:0] SLOW_LAST = OS_W'(SLOW - 1);

    typedef struct packed {
        logic [OS_W-1:0] cnt;
        logic            over_seen;
    } os_state_t;

    os_state_t       st_d, st_q;
    logic            over_change;
    logic [OS_W-1:0] last;

    always_comb begin
        st_d           = st_q;
        st_d.over_seen = over_i;
        over_change    = (over_i != st_q.over_seen);
        last           = st_q.over_seen ? FAST_LAST : SLOW_LAST;
        if (over_change) begin
            st_d.cnt = '0;
        end else if (samp_i) begin
            st_d.cnt = (st_q.cnt == last) ? '0 : st_q.cnt + OS_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_o = samp_i & ~over_change & (st_q.cnt == last);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import bg_pkg::*;
#(
    parameter int CD_W        = 16,
    parameter int OS_FAST     = 8,
    parameter int OS_SLOW     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            prediv_en_i,
    input  logic            ext_sck_i,
    input  logic [1:0]      src_sel_i,
    input  logic [CD_W-1:0] cd_i,
    input  logic            over_i,
    input  logic            sync_i,
    output logic            samp_en_o,
    output logic            baud_en_o
);
    bg_src_e sel;
    logic    ext_rise;
    logic    tick;
    logic    div_samp;
    logic    os_baud;
    logic    bypass;

    assign sel = bg_src_e'(src_sel_i);

    bg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_sck_i),
        .rise_o (ext_rise)
    );

    always_comb begin
        unique case (sel)
            SRC_SYS:    tick = 1'b1;
            SRC_PREDIV: tick = prediv_en_i;
            SRC_EXT:    tick = ext_rise;
            default:    tick = 1'b0;
        endcase
    end

    bg_divider #(.CD_W(CD_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .cd_i   (cd_i),
        .sel_i  (sel),
        .samp_o (div_samp)
    );

    bg_oversamp #(.FAST(OS_FAST), .SLOW(OS_SLOW)) u_os (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .samp_i (div_samp),
        .over_i (over_i),
        .baud_o (os_baud)
    );

    assign bypass    = sync_i && (sel == SRC_EXT);
    assign samp_en_o = bypass ? ext_rise : div_samp;
    assign baud_en_o = bypass ? ext_rise : os_baud;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
    parameter int CD_W = 16
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [1:0]      src_sel_i,
    input logic [CD_W-1:0] cd_i,
    input logic            sync_i,
    input logic            samp_en_o,
    input logic            baud_en_o
);
    logic byp;
    assign byp = sync_i && (src_sel_i == 2'd3);

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!samp_en_o && !baud_en_o));

    // R8
    baud_needs_samp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        baud_en_o |-> samp_en_o);

    // R4
    cd_zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cd_i == '0 && !byp) |=> (!samp_en_o || byp));

    // R6
    rsvd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_sel_i == 2'd2 && !byp) |=> (!samp_en_o || byp));

    // R9
    bypass_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byp |-> (samp_en_o == baud_en_o));

    // R3
    cd_one_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && cd_i == CD_W'(1) && $past(cd_i) == CD_W'(1)
         && src_sel_i == 2'd0 && $past(src_sel_i) == 2'd0)
        |=> (samp_en_o || byp));
endmodule

bind baud_gen baud_gen_chk #(.CD_W(CD_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_sel_i (src_sel_i),
    .cd_i      (cd_i),
    .sync_i    (sync_i),
    .samp_en_o (samp_en_o),
    .baud_en_o (baud_en_o)
);

// File: tb/baud_gen_tb.sv
`timescale 1ns/1ps
module baud_gen_tb;
    localparam int LIM = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prediv_en = 1'b0;
    logic        ext_sck = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic [15:0] cd = 16'd5;
    logic        over = 1'b0;
    logic        sync_m = 1'b0;
    logic        samp, baud;

    int total = 0;
    int bad = 0;
    int pd_period = 0;
    int pd_ph = 0;
    int ext_half = 0;
    int ext_ph = 0;
    int orphan = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    baud_gen u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .prediv_en_i (prediv_en),
        .ext_sck_i   (ext_sck),
        .src_sel_i   (src_sel),
        .cd_i        (cd),
        .over_i      (over),
        .sync_i      (sync_m),
        .samp_en_o   (samp),
        .baud_en_o   (baud)
    );

    // background pre-divider strobe
    initial forever begin
        @(negedge clk);
        if (pd_period > 0) begin
            pd_ph = pd_ph + 1;
            if (pd_ph >= pd_period) pd_ph = 0;
            prediv_en = (pd_ph == 0);
        end else begin
            prediv_en = 1'b0;
        end
    end

    // background external clock toggler
    initial forever begin
        @(negedge clk);
        if (ext_half > 0) begin
            ext_ph = ext_ph + 1;
            if (ext_ph >= ext_half) begin
                ext_ph = 0;
                ext_sck = ~ext_sck;
            end
        end
    end

    // R8 monitor: bit-rate pulse without a sampling pulse
    initial forever begin
        @(negedge clk);
        if (rst_n && baud && !samp) orphan = orphan + 1;
    end

    function automatic int exp_gap(int sel, int n, int m, int p);
        if (sel == 0) return n;
        if (sel == 1) return n * m;
        return n * p;
    endfunction

    function automatic int exp_spacing(logic ov);
        return ov ? 8 : 16;
    endfunction

    task automatic chk(string req, int act, int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_samp(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!samp && n < LIM);
        if (!samp) n = -1;
    endtask

    task automatic samp_gap(output int g);
        int d;
        wait_samp(d);
        wait_samp(g);
    endtask

    task automatic wait_baud();
        int n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!baud && n < LIM);
    endtask

    // sampling pulses from just after the current cycle up to and including next bit pulse
    task automatic baud_spacing(output int s);
        int n = 0;
        s = 0;
        do begin
            @(negedge clk);
            n = n + 1;
            if (samp) s = s + 1;
        end while (!baud && n < LIM * 4);
        if (!baud) s = -1;
    endtask

    task automatic count_pulses(input int cycles, output int ns, output int nb);
        ns = 0;
        nb = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (samp) ns = ns + 1;
            if (baud) nb = nb + 1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int g, s, ns, nb, n;
        void'($urandom(32'd2024));

        // R1: reset holds outputs low
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1 samp in reset", int'(samp), 0);
            chk("R1 baud in reset", int'(baud), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first pulse after release shows counters started cleared
        wait_samp(n);
        chk("R1 first pulse after release", n, 6);

        // R2: system clock, divisor 5
        samp_gap(g);
        chk("R2 gap cd=5", g, exp_gap(0, 5, 0, 0));
        // R8: 16x spacing
        wait_baud();
        baud_spacing(s);
        chk("R8 spacing over=0", s, exp_spacing(1'b0));

        // R11: flip over to 1, first bit pulse on 8th sampling pulse
        over = 1'b1;
        baud_spacing(s);
        chk("R11 restart to 8x", s, 8);
        baud_spacing(s);
        chk("R8 spacing over=1", s, exp_spacing(1'b1));
        // R11: flip back mid-count
        wait_samp(n);
        wait_samp(n);
        over = 1'b0;
        baud_spacing(s);
        chk("R11 restart to 16x", s, 16);

        // R10: divisor change reload latency
        wait_samp(n);
        @(negedge clk);
        cd = 16'd7;
        wait_samp(n);
        chk("R10 first pulse after cd change", n, 8);
        samp_gap(g);
        chk("R2 gap cd=7", g, 7);

        // R3: divisor 1 with system clock, 8x: bit pulse every 8 cycles
        cd = 16'd1;
        over = 1'b1;
        repeat (3) @(negedge clk);
        count_pulses(32, ns, nb);
        chk("R3 cd=1 every cycle", ns, 32);
        chk("R3 max rate bits in 32 cycles", nb, 4);

        // R3: divisor 1 on pre-divided source
        pd_period = 3;
        src_sel = 2'd1;
        samp_gap(g);
        chk("R3 cd=1 prediv gap", g, 3);

        // R5: pre-divided source, strobe every 4, divisor 3
        pd_period = 4;
        cd = 16'd3;
        samp_gap(g);
        chk("R5 gap", g, exp_gap(1, 3, 4, 0));

        // R4: divisor 0 stops everything
        src_sel = 2'd0;
        cd = 16'd0;
        repeat (2) @(negedge clk);
        count_pulses(300, ns, nb);
        chk("R4 samp with cd=0", ns, 0);
        chk("R4 baud with cd=0", nb, 0);

        // R6: reserved source
        src_sel = 2'd2;
        cd = 16'd3;
        repeat (2) @(negedge clk);
        count_pulses(300, ns, nb);
        chk("R6 samp reserved", ns, 0);
        chk("R6 baud reserved", nb, 0);

        // R7: external pin, async, half period 3 (period 6), divisor 2
        ext_half = 3;
        src_sel = 2'd3;
        cd = 16'd2;
        samp_gap(g);
        chk("R7 ext gap", g, exp_gap(3, 2, 0, 6));

        // R9: sync bypass, divisor 0 ignored, pin period 8
        ext_half = 4;
        cd = 16'd0;
        sync_m = 1'b1;
        samp_gap(g);
        chk("R9 bypass samp gap", g, 8);
        count_pulses(160, ns, nb);
        chk("R9 samp per pin edge", ns, 20);
        chk("R9 baud equals samp", nb, ns);

        // R12: sync with system clock source divides normally
        ext_half = 0;
        src_sel = 2'd0;
        cd = 16'd4;
        over = 1'b1;
        samp_gap(g);
        chk("R12 sync ignored gap", g, 4);
        wait_baud();
        baud_spacing(s);
        chk("R12 sync ignored spacing", s, 8);
        sync_m = 1'b0;

        // random rounds: R2/R5/R8
        for (int k = 0; k < 8; k++) begin
            int rs, rn, rm;
            logic ro;
            rs = int'($urandom_range(1, 0));
            rn = int'($urandom_range(9, 2));
            rm = int'($urandom_range(4, 2));
            ro = 1'($urandom_range(1, 0));
            pd_period = rm;
            src_sel = 2'(rs);
            cd = 16'(rn);
            over = ro;
            samp_gap(g);
            chk(rs == 0 ? "R2 random gap" : "R5 random gap", g, exp_gap(rs, rn, rm, 0));
            wait_baud();
            baud_spacing(s);
            chk("R8 random spacing", s, exp_spacing(ro));
        end

        chk("R8 baud without samp", orphan, 0);
        finish_run();
    end
endmodule